// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides, once per received frame, whether the frame's 48-bit destination address is wanted. It first looks for the address in a bank of sixteen exact-match entries. Each entry can be enabled or disabled on its own. When no enabled entry holds the address, the block falls back to an imperfect test. It forms a 12-bit hash from the two last address bytes and looks up one bit of a 4096-bit multicast table. A set bit accepts the frame.

The receive datapath presents the address with a one-cycle `start` strobe. The exact entries are scanned one per clock. The verdict arrives with a one-cycle `done` pulse, together with a flag telling whether an exact entry matched and that entry's index. Frames accepted by the hash path advance a saturating counter. Configuration software writes entries and table words through a simple write port. A write that lands while a lookup is running is held and applied when that lookup finishes, so every frame is judged against one consistent set of tables.

Top module: `rxf_dest_filter`

## Requirements
- R1: After synchronous reset, `done`, `accept`, `exact_hit`, `hit_index` and `mc_count` are zero, every exact entry is disabled and every table bit is clear, so the next frame is rejected.
- R2: Address byte i (byte 0 first on the wire) is `dst_addr[8i+7:8i]`. An enabled entry matches when its low word equals bytes 0..3 (byte i in bits [8i+7:8i]) and its high word bits [15:0] equal bytes 4 and 5 (byte 4 in [7:0]). A match gives `accept`=1, `exact_hit`=1 and `hit_index` equal to the entry number.
- R3: An entry whose enable bit (high word bit 31) is clear never matches, even when its address bytes are equal.
- R4: Entries are scanned from index 0 upward, one per clock, and the lowest matching index wins. For a match at entry k, `done` pulses k+1 cycles after the cycle in which `start` was sampled.
- R5: With no exact match, the hash is bits [11:0] of {byte5, byte4} shifted right by 4, 3, 2 or 0 for `hash_off` codes 0, 1, 2 and 3. Hash bits [11:5] pick the table word and bits [4:0] pick the bit. A set bit gives `accept`=1 with `exact_hit`=0 and `hit_index`=0, and `done` pulses 17 cycles after `start`.
- R6: With no exact match and a clear table bit, `accept`=0 and `exact_hit`=0.
- R7: `mc_count` increases by one for each hash-path accept and does not change on exact accepts or on rejects.
- R8: `mc_count` stops at all-ones and does not wrap.
- R9: A `start` pulse during a running lookup is ignored. It neither changes that lookup's result nor produces an extra `done`.
- R10: A write arriving while idle applies at once. A write arriving during a lookup does not affect that lookup and takes effect when it finishes. If several arrive during one lookup, only the last is applied.
- R11: Write map: `wr_addr[7]`=1 writes table word `wr_addr[6:0]`. `wr_addr[7]`=0 with `wr_addr[6:5]`=0 writes entry `wr_addr[4:1]`, the low word when `wr_addr[0]`=0 and the high word when it is 1. Any other exact-space address is dropped.
- R12: `dst_addr` and `hash_off` are captured when `start` is sampled. Later changes do not affect that lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a lookup of `dst_addr` |
| dst_addr | input | 48 | Destination address, byte 0 in bits [7:0] |
| hash_off | input | 2 | Hash window select |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 8 | Configuration write address |
| wr_data | input | 32 | Configuration write data |
| done | output | 1 | One-cycle pulse when a verdict is ready |
| accept | output | 1 | Verdict of the last lookup |
| exact_hit | output | 1 | Last accept came from an exact entry |
| hit_index | output | 4 | Matching entry index (0 on a hash result) |
| mc_count | output | CNT_W | Saturating count of hash-path accepts |

## Verification
The in-RTL assertions check on every cycle that `done` is a single-cycle pulse that never appears without a lookup in flight. They also check that an exact hit is always reported as an accept, and that the counter moves by at most one, never on an exact hit, and holds once full. The bench scenarios are what show the correctness of the verdict itself. That covers the lowest-index priority, the skipping of disabled entries, the four hash windows and their latencies, and the dropping of aliased writes. It also covers the deferral of writes made mid-lookup, with only the last one surviving, which no single-cycle property can see.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int MAC_W   = 48;
    localparam int HASH_W  = 12;
    localparam int BIT_W   = 5;
    localparam int HWORD_W = HASH_W - BIT_W;
    localparam int HWORDS  = 1 << HWORD_W;
    localparam int WR_AW   = HWORD_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_HASH = 2'd2
    } rxf_state_e;

    typedef struct packed {
        logic [WR_AW-1:0] addr;
        logic [31:0]      data;
    } rxf_wr_t;

    typedef struct packed {
        logic        valid;
        logic [15:0] hi;
        logic [31:0] lo;
    } rxf_entry_t;

    // Window select: codes 0..3 shift the top address bytes by 4,3,2,0.
    function automatic logic [HASH_W-1:0] rxf_hash(input logic [15:0] key,
                                                   input logic [1:0]  off);
        logic [15:0] sh;
        case (off)
            2'd0:    sh = key >> 4;
            2'd1:    sh = key >> 3;
            2'd2:    sh = key >> 2;
            default: sh = key;
        endcase
        return sh[HASH_W-1:0];
    endfunction

endpackage

// File: rtl/rxf_exact_bank.sv
module rxf_exact_bank
    import rxf_pkg::*;
#(
    parameter int NUM_EXACT = 16,
    localparam int IDX_W    = $clog2(NUM_EXACT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_entry,
    input  logic             wr_hi,
    input  logic [31:0]      wr_lo_data,
    input  logic [15:0]      wr_hi_data,
    input  logic             wr_valid,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [MAC_W-1:0] cmp_addr,
    output logic             match
);

    rxf_entry_t ent [NUM_EXACT];

    for (genvar g = 0; g < NUM_EXACT; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent[g] <= '0;
            end else if (wr_en && wr_entry == IDX_W'(g)) begin
                if (wr_hi) begin
                    ent[g].valid <= wr_valid;
                    ent[g].hi    <= wr_hi_data;
                end else begin
                    ent[g].lo    <= wr_lo_data;
                end
            end
        end
    end

    rxf_entry_t cur;
    always_comb begin
        cur   = ent[rd_idx];
        match = cur.valid && (cur.lo == cmp_addr[31:0]) && (cur.hi == cmp_addr[47:32]);
    end

endmodule

// File: rtl/rxf_hash_table.sv
module rxf_hash_table
    import rxf_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [HWORD_W-1:0] wr_word,
    input  logic [31:0]        wr_data,
    input  logic [15:0]        key,
    input  logic [1:0]         off,
    output logic               bit_hit
);

    logic [31:0] tbl [HWORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < HWORDS; i++) tbl[i] <= '0;
        end else if (wr_en) begin
            tbl[wr_word] <= wr_data;
        end
    end

    logic [HASH_W-1:0] h;
    logic [31:0]       w;
    always_comb begin
        h       = rxf_hash(key, off);
        w       = tbl[h[HASH_W-1:BIT_W]];
        bit_hit = w[h[BIT_W-1:0]];
    end

endmodule

// File: rtl/rxf_sat_counter.sv
module rxf_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] MAXV = '1;

    always_ff @(posedge clk) begin
        if (rst)                       count <= '0;
        else if (inc && count != MAXV) count <= count + 1'b1;
    end

    // R7: moves by at most one per cycle
    a_r7_count_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (count == $past(count)) || (count == $past(count) + 1'b1));

    // R8: once full it stays full
    a_r8_sat_hold: assert property (@(posedge clk) disable iff (rst)
        count == MAXV |=> count == MAXV);

endmodule

// File: rtl/rxf_dest_filter.sv
module rxf_dest_filter
    import rxf_pkg::*;
#(
    parameter int NUM_EXACT = 16,
    parameter int CNT_W     = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic [47:0]                  dst_addr,
    input  logic [1:0]                   hash_off,
    input  logic                         wr_en,
    input  logic [7:0]                   wr_addr,
    input  logic [31:0]                  wr_data,
    output logic                         done,
    output logic                         accept,
    output logic                         exact_hit,
    output logic [$clog2(NUM_EXACT)-1:0] hit_index,
    output logic [CNT_W-1:0]             mc_count
);

    localparam int IDX_W = $clog2(NUM_EXACT);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_EXACT - 1);

    rxf_state_e       state;
    logic [IDX_W-1:0] scan_idx;
    logic [MAC_W-1:0] addr_q;
    logic [1:0]       off_q;
    rxf_wr_t          pend;
    logic             pend_v;

    logic ex_match, h_hit;
    logic busy, finishing;

    assign busy      = (state != ST_IDLE);
    assign finishing = (state == ST_HASH) || (state == ST_SCAN && ex_match);

    // Write commit: direct when idle, deferred otherwise (latest wins).
    rxf_wr_t cw;
    logic    cw_v;
    always_comb begin
        cw   = wr_en ? rxf_wr_t'{addr: wr_addr, data: wr_data} : pend;
        cw_v = (!busy && wr_en) || (finishing && (wr_en || pend_v));
    end

    logic cw_tbl, cw_ent;
    assign cw_tbl = cw_v && cw.addr[WR_AW-1];
    assign cw_ent = cw_v && !cw.addr[WR_AW-1] && (cw.addr[WR_AW-2:IDX_W+1] == '0);

    rxf_exact_bank #(.NUM_EXACT(NUM_EXACT)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (cw_ent),
        .wr_entry   (cw.addr[IDX_W:1]),
        .wr_hi      (cw.addr[0]),
        .wr_lo_data (cw.data),
        .wr_hi_data (cw.data[15:0]),
        .wr_valid   (cw.data[31]),
        .rd_idx     (scan_idx),
        .cmp_addr   (addr_q),
        .match      (ex_match)
    );

    rxf_hash_table u_tbl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cw_tbl),
        .wr_word (cw.addr[HWORD_W-1:0]),
        .wr_data (cw.data),
        .key     (addr_q[47:32]),
        .off     (off_q),
        .bit_hit (h_hit)
    );

    rxf_sat_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (state == ST_HASH && h_hit),
        .count (mc_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            scan_idx  <= '0;
            addr_q    <= '0;
            off_q     <= '0;
            done      <= 1'b0;
            accept    <= 1'b0;
            exact_hit <= 1'b0;
            hit_index <= '0;
            pend      <= '0;
            pend_v    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (finishing)            pend_v <= 1'b0;
            else if (busy && wr_en) begin
                pend   <= '{addr: wr_addr, data: wr_data};
                pend_v <= 1'b1;
            end
            case (state)
                ST_IDLE: if (start) begin
                    addr_q   <= dst_addr;
                    off_q    <= hash_off;
                    scan_idx <= '0;
                    state    <= ST_SCAN;
                end
                ST_SCAN: begin
                    if (ex_match) begin
                        done      <= 1'b1;
                        accept    <= 1'b1;
                        exact_hit <= 1'b1;
                        hit_index <= scan_idx;
                        state     <= ST_IDLE;
                    end else if (scan_idx == LAST) begin
                        state     <= ST_HASH;
                    end else begin
                        scan_idx  <= scan_idx + 1'b1;
                    end
                end
                ST_HASH: begin
                    done      <= 1'b1;
                    accept    <= h_hit;
                    exact_hit <= 1'b0;
                    hit_index <= '0;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R4: verdict strobe lasts one cycle
    a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: no verdict appears without a lookup having been started
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !start) |=> !done);

    // R2: an exact hit is always an accept
    a_r2_hit_accepts: assert property (@(posedge clk) disable iff (rst)
        (done && exact_hit) |-> accept);

    // R7: exact hits leave the counter alone
    a_r7_exact_no_count: assert property (@(posedge clk) disable iff (rst)
        (done && exact_hit) |-> mc_count == $past(mc_count));

endmodule

// File: tb/rxf_dest_filter_tb_top.sv
`timescale 1ns/1ps
module rxf_dest_filter_tb_top;

    localparam int CW = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [47:0] dst_addr = '0;
    logic [1:0]  hash_off = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        done, accept, exact_hit;
    logic [3:0]  hit_index;
    logic [CW-1:0] mc_count;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] ref_lo  [16];
    logic [31:0] ref_hi  [16];
    logic [31:0] ref_mta [128];
    int          ref_cnt = 0;

    always #4 clk = ~clk;

    rxf_dest_filter #(.NUM_EXACT(16), .CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .start(start), .dst_addr(dst_addr),
        .hash_off(hash_off), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .done(done), .accept(accept),
        .exact_hit(exact_hit), .hit_index(hit_index), .mc_count(mc_count)
    );

    task automatic check(input string r, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", r, act, exp);
        end
    endtask

    function automatic logic [11:0] ref_hash(input logic [47:0] a, input logic [1:0] off);
        logic [15:0] k = {a[47:40], a[39:32]};
        int sh = (off == 2'd0) ? 4 : (off == 2'd1) ? 3 : (off == 2'd2) ? 2 : 0;
        return 12'((k >> sh) & 16'h0fff);
    endfunction

    task automatic mdl_write(input logic [7:0] a, input logic [31:0] d);
        if (a[7]) ref_mta[a[6:0]] = d;
        else if (a[6:5] == 2'b00) begin
            if (a[0]) ref_hi[a[4:1]] = d;
            else      ref_lo[a[4:1]] = d;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit now);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        if (now) mdl_write(a, d);
    endtask

    task automatic set_entry(input int k, input logic [47:0] a, input bit v);
        wr(8'(2*k),     a[31:0], 1'b1);
        wr(8'(2*k + 1), {v, 15'd0, a[47:32]}, 1'b1);
    endtask

    task automatic model(input logic [47:0] a, input logic [1:0] off,
                         output bit acc, output bit hit, output int idx, output int lat);
        logic [11:0] h;
        hit = 1'b0; idx = 0;
        for (int k = 15; k >= 0; k--)
            if (ref_hi[k][31] && ref_lo[k] == a[31:0] && ref_hi[k][15:0] == a[47:32]) begin
                hit = 1'b1; idx = k;
            end
        if (hit) begin acc = 1'b1; lat = idx + 1; end
        else begin
            h = ref_hash(a, off);
            acc = ref_mta[h[11:5]][h[4:0]];
            lat = 17;
        end
    endtask

    task automatic start_frame(input logic [47:0] a, input logic [1:0] off);
        start = 1'b1; dst_addr = a; hash_off = off;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(inout int cyc);
        while (!done && cyc < 60) begin
            @(posedge clk); @(negedge clk);
            cyc++;
        end
    endtask

    task automatic verdict(input string r, input bit acc, input bit hit, input int idx, input int lat, input int cyc);
        check({r, " latency"}, cyc, lat);
        check({r, " accept"}, accept, acc);
        check({r, " exact_hit"}, exact_hit, hit);
        check({r, " hit_index"}, hit_index, idx);
        if (acc && !hit && ref_cnt < (1 << CW) - 1) ref_cnt++;
        check({r, " mc_count"}, mc_count, ref_cnt);
    endtask

    task automatic run(input string r, input logic [47:0] a, input logic [1:0] off);
        bit acc, hit; int idx, lat, cyc;
        model(a, off, acc, hit, idx, lat);
        start_frame(a, off);
        cyc = 0;
        wait_done(cyc);
        verdict(r, acc, hit, idx, lat, cyc);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [47:0] A, B, C, D, E;
        logic [11:0] h;
        bit acc, hit; int idx, lat, cyc;
        void'($urandom(32'd1234));
        for (int i = 0; i < 16; i++) begin ref_lo[i] = '0; ref_hi[i] = '0; end
        for (int i = 0; i < 128; i++) ref_mta[i] = '0;
        A = 48'h5544_3322_1101; B = 48'hA7C3_0000_0003; C = 48'h0102_0304_0507;
        D = 48'h9988_7766_5509; E = 48'h1357_2468_ACE1;

        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1 reset state
        check("R1 done", done, 0);
        check("R1 accept", accept, 0);
        check("R1 exact_hit", exact_hit, 0);
        check("R1 hit_index", hit_index, 0);
        check("R1 mc_count", mc_count, 0);
        run("R1 empty tables reject", A, 2'd0);

        // R2/R4 exact match at entry 3
        set_entry(3, A, 1'b1);
        run("R2 R4 entry3", A, 2'd1);
        // R3 disabled entry 1 with same address is skipped
        set_entry(1, A, 1'b0);
        run("R3 disabled skipped", A, 2'd0);
        set_entry(1, A, 1'b1);
        run("R4 lowest index wins", A, 2'd0);

        // R11 aliased exact-space write is dropped
        wr(8'h32, C[31:0], 1'b1);
        wr(8'h13, {1'b1, 15'd0, C[47:32]}, 1'b1);
        run("R11 alias write dropped", C, 2'd0);
        wr(8'h12, C[31:0], 1'b1);
        run("R11 entry9 written", C, 2'd0);

        // R5/R6/R7 the four hash windows
        for (int o = 0; o < 4; o++) begin
            h = ref_hash(B, 2'(o));
            wr({1'b1, h[11:5]}, 32'd1 << h[4:0], 1'b1);
            run($sformatf("R5 R7 hash off%0d", o), B, 2'(o));
            wr({1'b1, h[11:5]}, 32'd0, 1'b1);
            run($sformatf("R6 hash off%0d clear", o), B, 2'(o));
        end
        run("R7 exact no count", A, 2'd2);

        // R12 offset captured at start
        h = ref_hash(B, 2'd0);
        wr({1'b1, h[11:5]}, 32'd1 << h[4:0], 1'b1);
        model(B, 2'd0, acc, hit, idx, lat);
        start_frame(B, 2'd0);
        hash_off = 2'd3; dst_addr = A;
        cyc = 0; wait_done(cyc);
        verdict("R12 captured inputs", acc, hit, idx, lat, cyc);
        wr({1'b1, h[11:5]}, 32'd0, 1'b1);

        // R9 start during busy ignored
        set_entry(12, D, 1'b1);
        model(D, 2'd0, acc, hit, idx, lat);
        start_frame(D, 2'd0);
        @(posedge clk); @(negedge clk);
        start = 1'b1; dst_addr = A;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        cyc = 2; wait_done(cyc);
        verdict("R9 busy start ignored", acc, hit, idx, lat, cyc);
        cyc = 0;
        repeat (25) begin @(posedge clk); @(negedge clk); if (done) cyc++; end
        check("R9 no extra done", cyc, 0);

        // R10 deferred writes, latest wins
        wr(8'h1E, E[31:0], 1'b1);
        wr(8'h1F, {1'b0, 15'd0, E[47:32]}, 1'b1);
        h = ref_hash(E, 2'd0);
        wr({1'b1, h[11:5]}, 32'd0, 1'b1);
        model(E, 2'd0, acc, hit, idx, lat);
        start_frame(E, 2'd0);
        wr(8'h1F, {1'b1, 15'd0, E[47:32]}, 1'b0);
        wr({1'b1, h[11:5]}, 32'd1 << h[4:0], 1'b0);
        cyc = 2; wait_done(cyc);
        verdict("R10 current frame unaffected", acc, hit, idx, lat, cyc);
        mdl_write({1'b1, h[11:5]}, 32'd1 << h[4:0]);
        run("R10 latest write applied", E, 2'd0);

        // random phase
        for (int k = 0; k < 16; k++) begin
            logic [47:0] ra = {16'($urandom), $urandom};
            set_entry(k, ra, 1'($urandom));
        end
        for (int w = 0; w < 128; w++) wr({1'b1, 7'(w)}, $urandom & $urandom & $urandom, 1'b1);
        for (int n = 0; n < 60; n++) begin
            int k = $urandom % 16;
            logic [47:0] a = ($urandom % 2) ? {ref_hi[k][15:0], ref_lo[k]} : {16'($urandom), $urandom};
            run("R2 R5 R6 random", a, 2'($urandom));
        end

        // R8 saturation
        h = ref_hash(B, 2'd0);
        wr({1'b1, h[11:5]}, 32'hFFFF_FFFF, 1'b1);
        for (int n = 0; n < 18; n++) run("R8 saturating", B, 2'd0);
        check("R8 count at all-ones", mc_count, (1 << CW) - 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule